// File: doc/BRIEF.md
# Host Processor Bus Port with Bus-Style Detection

This block is the slave side of an 8-bit host processor port on a switching device. A mode pin chooses how it works. In one mode a separate 10-bit address bus is used. In the other mode address and data share one 8-bit bus, and an address strobe latches the address. In the shared-bus mode the port works out the host's timing style by itself. It supports either a data strobe with a read/write direction line, or separate active-low read and write strobes. The host does not need to configure this.

Each access goes to one of two places. The first is a small control register space: one page register held inside the port, with the other offsets passed to an external register port. The second is one of three external memories, reached through an 11-bit paged address. Each bus cycle gives exactly one single-clock read or write strobe on the matching port. The port acknowledges the cycle on an active-low acknowledge output. All bus pins are sampled on the system clock.

Top module: `hostbus_port`

## Requirements
- R1: With `mux_mode` low, the port uses `nm_addr[9:0]` as the address. Addresses with bits 9..7 all ones reach the control register space at offset `nm_addr[6:0]`, so 0x3E1 is the page register. Any other address is a memory access using low byte `nm_addr[7:0]`.
- R2: With `mux_mode` high, the address byte is taken from `ad_in` on the falling edge of `as_ale`. It is held until the next falling edge.
- R3: With `mux_mode` high, the bus style is set at each rising edge of `as_ale` and held until the next rising edge. `dsrd` low at that edge selects direction style: a cycle is active while `cs_n` is low and `dsrd` is high, and `rwwr` high means read. `dsrd` high selects split-strobe style: with `cs_n` low, `dsrd` low means read and `rwwr` low means write.
- R4: With `mux_mode` low, a cycle is active while `cs_n` and `dsrd` are both low, and `rwwr` high means read.
- R5: A latched shared-bus address with bit 7 clear is a control register offset in bits 6..0. Offset 0x61 is the internal page register, readable and writable. Its bits 2..0 are the page. Every other offset goes to `reg_addr` with `reg_re` or `reg_we`.
- R6: A memory access drives `mem_addr = {page, low byte}`. Page bits 2..1 pick the target: 00 is connection memory low (`cml_*`), 01 is connection memory high (`cmh_*`), 10 is data memory (`dm_*`).
- R7: Data memory is read-only. A write with page bits 2..1 = 10 gives no strobe of any kind.
- R8: A page with bits 2..1 = 11 returns 0x00 on reads and gives no strobe on reads or writes.
- R9: `dta_n` goes low after the second rising clock edge that follows the first edge sampling an active cycle. It returns high after the first edge that samples the cycle inactive.
- R10: `ad_oe` is high only while a read cycle is sampled active. At acknowledge, `ad_out` holds the data read.
- R11: Each bus cycle to a valid external target gives exactly one strobe, one clock long. Writes to the page register give none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mux_mode | input | 1 | 1 = shared address/data bus, 0 = separate address bus |
| cs_n | input | 1 | Chip select, active low |
| dsrd | input | 1 | Data strobe (direction style) or read strobe (split style) |
| rwwr | input | 1 | Read/write direction or write strobe |
| as_ale | input | 1 | Address strobe / latch enable for the shared bus |
| nm_addr | input | 10 | Address in separate-bus mode |
| ad_in | input | 8 | Address/data bus inbound |
| ad_out | output | 8 | Read data outbound |
| ad_oe | output | 1 | Output enable for `ad_out` |
| dta_n | output | 1 | Data acknowledge, active low |
| reg_addr | output | 7 | External control register offset |
| reg_re | output | 1 | External register read strobe |
| reg_we | output | 1 | External register write strobe |
| reg_rdata | input | 8 | External register read data |
| mem_addr | output | 11 | Paged memory address |
| cml_re | output | 1 | Connection memory low read strobe |
| cml_we | output | 1 | Connection memory low write strobe |
| cml_rdata | input | 8 | Connection memory low read data |
| cmh_re | output | 1 | Connection memory high read strobe |
| cmh_we | output | 1 | Connection memory high write strobe |
| cmh_rdata | input | 8 | Connection memory high read data |
| dm_re | output | 1 | Data memory read strobe |
| dm_rdata | input | 8 | Data memory read data |
| wr_data | output | 8 | Write data for registers and memories |

## Verification
Some behaviour is checked on every cycle by assertions:
- the detected style and the latched address stay put between their strobe edges;
- the acknowledge falls only after the cycle has been active for three samples;
- no more than one strobe is ever high, a start pulse lasts one clock, and the unmapped page never strobes;
- the output enable never overlaps a write.

Other behaviour only the bench scenarios can show, with the bench acting as the memories and comparing `dta_n` and `ad_oe` against its own timing model on every clock:
- both styles are detected from real cycles;
- data written through either mode comes back through the other;
- data memory contents survive a write attempt;
- the unmapped page reads as zero.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_PAGE = 3'd1,
    TGT_REG  = 3'd2,
    TGT_CML  = 3'd3,
    TGT_CMH  = 3'd4,
    TGT_DM   = 3'd5
  } hb_tgt_e;
endpackage

// File: rtl/hb_front.sv
// Samples bus pins, finds address strobe edges, latches the address byte
// and the detected bus style.
module hb_front #(
  parameter int DW  = 8,
  parameter int NAW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mux_mode,
  input  logic           cs_n,
  input  logic           dsrd,
  input  logic           rwwr,
  input  logic           as_ale,
  input  logic [NAW-1:0] nm_addr,
  input  logic [DW-1:0]  ad_in,
  output logic           mux_q,
  output logic           cs_q,
  output logic           dsrd_q,
  output logic           rwwr_q,
  output logic [NAW-1:0] nm_addr_q,
  output logic [DW-1:0]  ad_q,
  output logic           sep_strobe,
  output logic [DW-1:0]  addr_lat
);
  logic as_q, as_p;
  logic as_rise, as_fall;
  logic sep_en, lat_en;

  always_comb begin
    as_rise = as_q & ~as_p;
    as_fall = ~as_q & as_p;
    sep_en  = mux_q & as_rise;
    lat_en  = mux_q & as_fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_q     <= 1'b0;
      cs_q      <= 1'b1;
      dsrd_q    <= 1'b1;
      rwwr_q    <= 1'b1;
      as_q      <= 1'b0;
      as_p      <= 1'b0;
      nm_addr_q <= '0;
      ad_q      <= '0;
    end else begin
      mux_q     <= mux_mode;
      cs_q      <= cs_n;
      dsrd_q    <= dsrd;
      rwwr_q    <= rwwr;
      as_q      <= as_ale;
      as_p      <= as_q;
      nm_addr_q <= nm_addr;
      ad_q      <= ad_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sep_strobe <= 1'b0;
      addr_lat   <= '0;
    end else begin
      if (sep_en) sep_strobe <= dsrd_q;
      if (lat_en) addr_lat   <= ad_q;
    end
  end

  a_r3_style_held : assert property (@(posedge clk) disable iff (!rst_n)
    !as_q |=> $stable(sep_strobe));
  a_r2_addr_held : assert property (@(posedge clk) disable iff (!rst_n)
    as_q |=> $stable(addr_lat));
endmodule

// File: rtl/hb_decode.sv
// Forms the target and the paged memory address from the current address
// source and the page field.
module hb_decode
  import hb_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          NAW      = 10,
  parameter int          RAW      = 7,
  parameter int          PG_W     = 3,
  parameter logic [6:0]  PAGE_OFF = 7'h61,
  localparam int         MAW      = PG_W + DW
) (
  input  logic            mux_q,
  input  logic [DW-1:0]   addr_lat,
  input  logic [NAW-1:0]  nm_addr_q,
  input  logic [PG_W-1:0] page,
  output hb_tgt_e         tgt,
  output logic [RAW-1:0]  reg_addr,
  output logic [MAW-1:0]  mem_addr
);
  logic          regspace;
  logic [DW-1:0] low;

  always_comb begin
    if (mux_q) begin
      low      = addr_lat;
      regspace = ~addr_lat[DW-1];
    end else begin
      low      = nm_addr_q[DW-1:0];
      regspace = &nm_addr_q[NAW-1:RAW];
    end
    reg_addr = low[RAW-1:0];
    mem_addr = {page, low};
    if (regspace) begin
      tgt = (reg_addr == PAGE_OFF[RAW-1:0]) ? TGT_PAGE : TGT_REG;
    end else begin
      case (page[PG_W-1 -: 2])
        2'b00:   tgt = TGT_CML;
        2'b01:   tgt = TGT_CMH;
        2'b10:   tgt = TGT_DM;
        default: tgt = TGT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/hb_cycle.sv
// Qualifies strobes for the active bus style, emits the start pulse and
// times the acknowledge.
module hb_cycle #(
  parameter int  DTA_DLY = 2,
  localparam int CW      = $clog2(DTA_DLY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mux_q,
  input  logic sep_strobe,
  input  logic cs_q,
  input  logic dsrd_q,
  input  logic rwwr_q,
  output logic act,
  output logic is_rd,
  output logic start,
  output logic dta_n
);
  logic [CW-1:0] cnt, cnt_d;
  logic          cnt_done;

  always_comb begin
    if (!mux_q) begin
      act   = ~cs_q & ~dsrd_q;
      is_rd = rwwr_q;
    end else if (!sep_strobe) begin
      act   = ~cs_q & dsrd_q;
      is_rd = rwwr_q;
    end else begin
      act   = ~cs_q & (~dsrd_q | ~rwwr_q);
      is_rd = ~dsrd_q;
    end
    cnt_done = (cnt == CW'(DTA_DLY));
    start    = act & (cnt == '0);
    dta_n    = ~(act & cnt_done);
    if (!act)          cnt_d = '0;
    else if (cnt_done) cnt_d = cnt;
    else               cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  a_r9_ack_after_delay : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dta_n) |-> act && $past(act) && $past(act, 2));
  a_r11_single_start : assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
endmodule

// File: rtl/hostbus_port.sv
module hostbus_port
  import hb_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          NAW      = 10,
  parameter int          RAW      = 7,
  parameter int          PG_W     = 3,
  parameter int          DTA_DLY  = 2,
  parameter logic [6:0]  PAGE_OFF = 7'h61,
  localparam int         MAW      = PG_W + DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mux_mode,
  input  logic           cs_n,
  input  logic           dsrd,
  input  logic           rwwr,
  input  logic           as_ale,
  input  logic [NAW-1:0] nm_addr,
  input  logic [DW-1:0]  ad_in,
  output logic [DW-1:0]  ad_out,
  output logic           ad_oe,
  output logic           dta_n,
  output logic [RAW-1:0] reg_addr,
  output logic           reg_re,
  output logic           reg_we,
  input  logic [DW-1:0]  reg_rdata,
  output logic [MAW-1:0] mem_addr,
  output logic           cml_re,
  output logic           cml_we,
  input  logic [DW-1:0]  cml_rdata,
  output logic           cmh_re,
  output logic           cmh_we,
  input  logic [DW-1:0]  cmh_rdata,
  output logic           dm_re,
  input  logic [DW-1:0]  dm_rdata,
  output logic [DW-1:0]  wr_data
);
  logic [1:0]     rs_q;
  logic           rst_i;
  logic           mux_q, cs_q, dsrd_q, rwwr_q, sep_strobe;
  logic [NAW-1:0] nm_addr_q;
  logic [DW-1:0]  ad_q, addr_lat;
  logic           act, is_rd, start;
  hb_tgt_e        tgt;
  logic [DW-1:0]  ctl_q, rd_hold, rmux;
  logic           rd_go, wr_go, ctl_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  hb_front #(.DW(DW), .NAW(NAW)) u_front (
    .clk(clk), .rst_n(rst_i), .mux_mode(mux_mode), .cs_n(cs_n),
    .dsrd(dsrd), .rwwr(rwwr), .as_ale(as_ale), .nm_addr(nm_addr),
    .ad_in(ad_in), .mux_q(mux_q), .cs_q(cs_q), .dsrd_q(dsrd_q),
    .rwwr_q(rwwr_q), .nm_addr_q(nm_addr_q), .ad_q(ad_q),
    .sep_strobe(sep_strobe), .addr_lat(addr_lat)
  );

  hb_decode #(.DW(DW), .NAW(NAW), .RAW(RAW), .PG_W(PG_W),
              .PAGE_OFF(PAGE_OFF)) u_dec (
    .mux_q(mux_q), .addr_lat(addr_lat), .nm_addr_q(nm_addr_q),
    .page(ctl_q[PG_W-1:0]), .tgt(tgt), .reg_addr(reg_addr),
    .mem_addr(mem_addr)
  );

  hb_cycle #(.DTA_DLY(DTA_DLY)) u_cyc (
    .clk(clk), .rst_n(rst_i), .mux_q(mux_q), .sep_strobe(sep_strobe),
    .cs_q(cs_q), .dsrd_q(dsrd_q), .rwwr_q(rwwr_q), .act(act),
    .is_rd(is_rd), .start(start), .dta_n(dta_n)
  );

  always_comb begin
    rd_go  = start & is_rd;
    wr_go  = start & ~is_rd;
    ctl_en = wr_go & (tgt == TGT_PAGE);
    reg_re = rd_go & (tgt == TGT_REG);
    reg_we = wr_go & (tgt == TGT_REG);
    cml_re = rd_go & (tgt == TGT_CML);
    cml_we = wr_go & (tgt == TGT_CML);
    cmh_re = rd_go & (tgt == TGT_CMH);
    cmh_we = wr_go & (tgt == TGT_CMH);
    dm_re  = rd_go & (tgt == TGT_DM);
    case (tgt)
      TGT_PAGE: rmux = ctl_q;
      TGT_REG:  rmux = reg_rdata;
      TGT_CML:  rmux = cml_rdata;
      TGT_CMH:  rmux = cmh_rdata;
      TGT_DM:   rmux = dm_rdata;
      default:  rmux = '0;
    endcase
    wr_data = ad_q;
    ad_out  = rd_hold;
    ad_oe   = act & is_rd;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctl_q   <= '0;
      rd_hold <= '0;
    end else begin
      if (ctl_en) ctl_q   <= ad_q;
      if (rd_go)  rd_hold <= rmux;
    end
  end

  a_r11_one_strobe : assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0({reg_re, reg_we, cml_re, cml_we, cmh_re, cmh_we, dm_re, ctl_en}));
  a_r8_hole_quiet : assert property (@(posedge clk) disable iff (!rst_i)
    (mem_addr[MAW-1 -: 2] == 2'b11 && tgt != TGT_PAGE && tgt != TGT_REG)
      |-> !(cml_re || cml_we || cmh_re || cmh_we || dm_re));
  a_r10_oe_not_write : assert property (@(posedge clk) disable iff (!rst_i)
    ad_oe |-> !(reg_we || cml_we || cmh_we || ctl_en));
endmodule

// File: tb/sim_hostbus_port.sv
module sim_hostbus_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mux_mode = 1'b0, cs_n = 1'b1, dsrd = 1'b1, rwwr = 1'b1, as_ale = 1'b0;
  logic [9:0]  nm_addr = '0;
  logic [7:0]  ad_in = '0;
  logic [7:0]  ad_out, reg_rdata, cml_rdata, cmh_rdata, dm_rdata, wr_data;
  logic        ad_oe, dta_n, reg_re, reg_we, cml_re, cml_we, cmh_re, cmh_we, dm_re;
  logic [6:0]  reg_addr;
  logic [10:0] mem_addr;

  logic [7:0] reg_m [0:127];
  logic [7:0] cml_m [0:511];
  logic [7:0] cmh_m [0:511];
  logic [7:0] dm_m  [0:511];

  int nchk = 0, nfail = 0, nstb = 0;
  bit done = 1'b0;
  bit m_act = 1'b0, m_rd = 1'b0, m_sep = 1'b0, as_prev = 1'b0;
  int m_cnt = 0;

  always #10 clk = ~clk;

  hostbus_port u0 (
    .clk(clk), .rst_n(rst_n), .mux_mode(mux_mode), .cs_n(cs_n), .dsrd(dsrd),
    .rwwr(rwwr), .as_ale(as_ale), .nm_addr(nm_addr), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .dta_n(dta_n), .reg_addr(reg_addr),
    .reg_re(reg_re), .reg_we(reg_we), .reg_rdata(reg_rdata),
    .mem_addr(mem_addr), .cml_re(cml_re), .cml_we(cml_we),
    .cml_rdata(cml_rdata), .cmh_re(cmh_re), .cmh_we(cmh_we),
    .cmh_rdata(cmh_rdata), .dm_re(dm_re), .dm_rdata(dm_rdata),
    .wr_data(wr_data)
  );

  // bench acts as the register file and memories
  assign reg_rdata = reg_m[reg_addr];
  assign cml_rdata = cml_m[mem_addr[8:0]];
  assign cmh_rdata = cmh_m[mem_addr[8:0]];
  assign dm_rdata  = dm_m[mem_addr[8:0]];

  initial for (int i = 0; i < 512; i++) dm_m[i] = 8'(i * 7 + 3);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) begin cml_m[i] <= '0; cmh_m[i] <= '0; end
      for (int i = 0; i < 128; i++) reg_m[i] <= '0;
    end else begin
      if (reg_we) reg_m[reg_addr] <= wr_data;
      if (cml_we) cml_m[mem_addr[8:0]] <= wr_data;
      if (cmh_we) cmh_m[mem_addr[8:0]] <= wr_data;
      if (reg_re | reg_we | cml_re | cml_we | cmh_re | cmh_we | dm_re) nstb++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural timing model: acknowledge and output enable
  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_cnt = 0; m_sep = 0; as_prev = 0; m_rd = 0;
    end else begin
      if (!m_act) m_cnt = 0; else if (m_cnt < 2) m_cnt++;
      if (mux_mode && as_ale && !as_prev) m_sep = dsrd;
      as_prev = as_ale;
      if (!mux_mode) begin m_act = !cs_n && !dsrd; m_rd = rwwr; end
      else if (!m_sep) begin m_act = !cs_n && dsrd; m_rd = rwwr; end
      else begin m_act = !cs_n && (!dsrd || !rwwr); m_rd = !dsrd; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(dta_n === !(m_act && m_cnt == 2), "R9 dta timing", int'(dta_n), int'(!(m_act && m_cnt == 2)));
      chk(ad_oe === (m_act && m_rd), "R10 read drive", int'(ad_oe), int'(m_act && m_rd));
    end
  end

  task automatic bus(input bit mx, input bit sep, input logic [9:0] a,
                     input bit rd, input logic [7:0] wd, output logic [7:0] rv);
    bit got;
    @(negedge clk);
    mux_mode = mx;
    if (mx) begin
      dsrd = sep; rwwr = 1'b1; ad_in = a[7:0];
      @(negedge clk); as_ale = 1'b1;
      repeat (2) @(negedge clk);
      as_ale = 1'b0;
      repeat (2) @(negedge clk);
      ad_in = wd; cs_n = 1'b0;
      if (sep) begin if (rd) dsrd = 1'b0; else rwwr = 1'b0; end
      else begin rwwr = rd; dsrd = 1'b1; end
    end else begin
      nm_addr = a; rwwr = rd; ad_in = wd; dsrd = 1'b1;
      @(negedge clk); cs_n = 1'b0; dsrd = 1'b0;
    end
    got = 1'b0;
    rv = '0;
    for (int k = 0; k < 20 && !got; k++) begin
      @(negedge clk);
      if (!dta_n) begin got = 1'b1; rv = ad_out; end
    end
    chk(got, "R9 acknowledge seen", int'(got), 1);
    cs_n = 1'b1; rwwr = 1'b1; dsrd = (mx && !sep) ? 1'b0 : 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input bit mx, input bit sep, input logic [9:0] a, input logic [7:0] d);
    logic [7:0] unused;
    bus(mx, sep, a, 1'b0, d, unused);
  endtask

  task automatic rd(input bit mx, input bit sep, input logic [9:0] a, output logic [7:0] v);
    bus(mx, sep, a, 1'b1, 8'h00, v);
  endtask

  task automatic report;
    done = 1'b1;
    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    logic [7:0] v;
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(dta_n === 1'b1, "R9 reset dta", int'(dta_n), 1);
    chk(ad_oe === 1'b0, "R10 reset oe", int'(ad_oe), 0);

    // R1 R4 R5: page register at 0x3E1 in separate-bus mode
    n0 = nstb;
    wr(0, 0, 10'h3E1, 8'h80);
    rd(0, 0, 10'h3E1, v);
    chk(v == 8'h80, "R1 page reg readback", v, 8'h80);
    chk(nstb == n0, "R11 page reg no strobe", nstb - n0, 0);
    // R4 R5: external register through separate bus
    wr(0, 0, 10'h385, 8'h5A);
    chk(reg_m[5] == 8'h5A, "R5 ext reg written", reg_m[5], 8'h5A);
    rd(0, 0, 10'h385, v);
    chk(v == 8'h5A, "R4 ext reg read", v, 8'h5A);
    // R6 R11: page 0 -> connection memory low
    n0 = nstb;
    wr(0, 0, 10'h012, 8'h33);
    chk(nstb - n0 == 1, "R11 one strobe", nstb - n0, 1);
    chk(cml_m[9'h012] == 8'h33, "R6 cml write", cml_m[9'h012], 8'h33);

    // R3 direction style, R2 latch, R5: set page 2 over shared bus
    wr(1, 0, 10'h061, 8'h82);
    rd(1, 0, 10'h061, v);
    chk(v == 8'h82, "R3 R5 page via shared bus", v, 8'h82);
    wr(1, 0, 10'h09C, 8'h44);
    chk(cmh_m[9'h09C] == 8'h44, "R6 cmh write", cmh_m[9'h09C], 8'h44);
    rd(1, 0, 10'h09C, v);
    chk(v == 8'h44, "R2 latched addr read", v, 8'h44);
    // R3 split-strobe style, page 3 -> cmh upper half
    wr(1, 1, 10'h061, 8'h03);
    wr(1, 1, 10'h0A0, 8'h77);
    chk(cmh_m[9'h1A0] == 8'h77, "R3 split write", cmh_m[9'h1A0], 8'h77);
    rd(1, 1, 10'h0A0, v);
    chk(v == 8'h77, "R3 split read", v, 8'h77);
    // R1 cross-check: read back through separate bus with page 0
    wr(1, 1, 10'h061, 8'h80);
    rd(0, 0, 10'h012, v);
    chk(v == 8'h33, "R1 memory via separate bus", v, 8'h33);
    rd(1, 0, 10'h012, v);
    chk(v == 8'h00, "R5 bit7 clear is register", v, 8'h00);

    // R7: data memory read, write ignored
    wr(1, 1, 10'h061, 8'h04);
    rd(1, 1, 10'h085, v);
    chk(v == 8'(9'h085 * 7 + 3), "R6 dm read", v, 8'(9'h085 * 7 + 3));
    n0 = nstb;
    wr(1, 1, 10'h085, 8'hFF);
    chk(nstb == n0, "R7 dm write no strobe", nstb - n0, 0);
    rd(1, 0, 10'h085, v);
    chk(v == 8'(9'h085 * 7 + 3), "R7 dm unchanged", v, 8'(9'h085 * 7 + 3));

    // R8: unmapped page
    wr(1, 0, 10'h061, 8'h06);
    n0 = nstb;
    wr(1, 0, 10'h090, 8'h12);
    chk(nstb == n0, "R8 hole write no strobe", nstb - n0, 0);
    rd(1, 0, 10'h090, v);
    chk(v == 8'h00, "R8 hole read zero", v, 8'h00);
    chk(nstb == n0, "R8 hole read no strobe", nstb - n0, 0);
    report();
  end
endmodule